// File: doc/BRIEF.md
# Ethernet Pause Frame Generator

This block builds a complete flow-control pause frame and streams it out one byte at a time. A single-cycle start request latches a 16-bit pause time and the 48-bit station address. The block then emits every byte from the line preamble up to and including the frame check sequence. The frame carries the reserved flow-control multicast destination, the MAC control type, the pause opcode, the pause time, zero padding and a CRC-32 that the block computes internally.

The output uses a ready/valid handshake, so a downstream transmit path can stall it on any byte. Each byte is tagged with a first and a last marker. A busy flag covers the whole frame, and start requests that arrive while it is set are discarded. Choosing between this frame and normal data traffic, driving a PHY and line coding belong to other blocks.

Top module: `pause_frame_gen`

## Requirements
- R1: While rst_ni is low and directly after reset, valid_o, busy_o, first_o and last_o are 0.
- R2: A frame is exactly 72 bytes long. Bytes 0..6 are 0x55 and byte 7 is 0xD5. first_o is 1 only on byte 0.
- R3: Bytes 8..13 are the destination address, sent in this order: 0x01, 0x80, 0xC2, 0x00, 0x00, 0x01.
- R4: Bytes 14..19 carry the latched source address, most significant byte first (src_addr_i[47:40] goes first).
- R5: Bytes 20..23 are 0x88, 0x08 (type), then 0x00, 0x01 (opcode).
- R6: Bytes 24..25 carry the latched quanta, high byte first. Bytes 26..67 are 42 bytes of 0x00.
- R7: Bytes 68..71 are the CRC-32 over bytes 8..67. The CRC uses the reflected polynomial 0xEDB88320 and starts from 0xFFFFFFFF. The final value is inverted and sent least significant byte first. Running the same CRC over bytes 8..71 leaves the residue 0xDEBB20E3.
- R8: A start_i seen while busy_o is 0 is accepted and latches quanta_i and src_addr_i. busy_o is 1 from the next cycle until the final byte is accepted. A start_i seen while busy_o is 1 has no effect on the frame or its length.
- R9: While valid_o is 1 and ready_i is 0, data_o, first_o and last_o hold their values in the next cycle.
- R10: last_o is 1 only on byte 71. After that byte is accepted, valid_o and busy_o are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send a pause frame |
| quanta_i | input | 16 | Pause time in quanta |
| src_addr_i | input | 48 | Station source address |
| busy_o | output | 1 | A frame is being sent |
| data_o | output | 8 | Output byte |
| valid_o | output | 1 | data_o is valid |
| ready_i | input | 1 | Downstream accepts data_o |
| first_o | output | 1 | Current byte is the first of the frame |
| last_o | output | 1 | Current byte is the last of the frame |

## Verification
Several rules are checked by assertions on every cycle: a stalled byte stays unchanged, the first marker always sits on a preamble byte, busy stays set through a frame, and the stream stops right after the last byte. Only the bench scenarios can show the byte contents. These include the address and quanta order, the padding count and the CRC value and residue. They also show that a start request during a frame is ignored, which takes frames with varied quanta, varied addresses and varied ready stall patterns.

// File: rtl/pfg_pkg.sv
`timescale 1ns/1ps
package pfg_pkg;
  localparam int QUANTA_W  = 16;
  localparam int ADDR_W    = 48;
  localparam int PRE_LEN   = 8;
  localparam int DA_OFF    = PRE_LEN;
  localparam int SA_OFF    = DA_OFF + ADDR_W/8;
  localparam int TYPE_OFF  = SA_OFF + ADDR_W/8;
  localparam int OP_OFF    = TYPE_OFF + 2;
  localparam int Q_OFF     = OP_OFF + 2;
  localparam int PAD_OFF   = Q_OFF + QUANTA_W/8;
  localparam int PAD_LEN   = 42;
  localparam int FCS_OFF   = PAD_OFF + PAD_LEN;
  localparam int FRAME_LEN = FCS_OFF + 4;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  localparam logic [IDX_W-1:0] IDX_CRC_LO = IDX_W'(DA_OFF);
  localparam logic [IDX_W-1:0] IDX_CRC_HI = IDX_W'(FCS_OFF - 1);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(FRAME_LEN - 1);

  localparam logic [47:0] CTRL_DA   = 48'h0180C2000001;
  localparam logic [15:0] CTRL_TYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OP  = 16'h0001;
  localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT  = 32'hFFFFFFFF;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/pfg_byte_sel.sv
`timescale 1ns/1ps
module pfg_byte_sel import pfg_pkg::*; (
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [QUANTA_W-1:0] quanta_i,
  input  logic [ADDR_W-1:0]   src_i,
  input  logic [31:0]         fcs_i,
  output logic [7:0]          byte_o
);
  int i;
  always_comb begin
    i = int'(idx_i);
    if (i < PRE_LEN - 1)       byte_o = 8'h55;
    else if (i < DA_OFF)       byte_o = 8'hD5;
    else if (i < SA_OFF)       byte_o = CTRL_DA[8*(SA_OFF-1-i) +: 8];
    else if (i < TYPE_OFF)     byte_o = src_i[8*(TYPE_OFF-1-i) +: 8];
    else if (i < OP_OFF)       byte_o = CTRL_TYPE[8*(OP_OFF-1-i) +: 8];
    else if (i < Q_OFF)        byte_o = PAUSE_OP[8*(Q_OFF-1-i) +: 8];
    else if (i < PAD_OFF)      byte_o = quanta_i[8*(PAD_OFF-1-i) +: 8];
    else if (i < FCS_OFF)      byte_o = 8'h00;
    else if (i < FRAME_LEN)    byte_o = fcs_i[8*(i-FCS_OFF) +: 8];
    else                       byte_o = 8'h00;
  end
endmodule

// File: rtl/pfg_crc.sv
`timescale 1ns/1ps
module pfg_crc import pfg_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] fcs_o
);
  logic [31:0] crc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (init_i) crc_q <= CRC_INIT;
    else if (en_i)   crc_q <= crc_step(crc_q, byte_i);
  end
  assign fcs_o = ~crc_q;
endmodule

// File: rtl/pause_frame_gen.sv
`timescale 1ns/1ps
module pause_frame_gen import pfg_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [QUANTA_W-1:0] quanta_i,
  input  logic [ADDR_W-1:0]   src_addr_i,
  output logic                busy_o,
  output logic [7:0]          data_o,
  output logic                valid_o,
  input  logic                ready_i,
  output logic                first_o,
  output logic                last_o
);
  logic                busy_q;
  logic [IDX_W-1:0]    idx_q;
  logic [QUANTA_W-1:0] quanta_q;
  logic [ADDR_W-1:0]   sa_q;
  logic                accept, xfer, crc_en;
  logic [31:0]         fcs;

  assign accept = start_i && !busy_q;
  assign xfer   = busy_q && ready_i;
  assign crc_en = xfer && (idx_q >= IDX_CRC_LO) && (idx_q <= IDX_CRC_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      idx_q    <= '0;
      quanta_q <= '0;
      sa_q     <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      idx_q    <= '0;
      quanta_q <= quanta_i;
      sa_q     <= src_addr_i;
    end else if (xfer) begin
      if (idx_q == IDX_LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  pfg_byte_sel u_sel (
    .idx_i    (idx_q),
    .quanta_i (quanta_q),
    .src_i    (sa_q),
    .fcs_i    (fcs),
    .byte_o   (data_o)
  );

  // CRC restarts on each accepted request; covers destination through padding
  pfg_crc u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (accept),
    .en_i   (crc_en),
    .byte_i (data_o),
    .fcs_o  (fcs)
  );

  assign busy_o  = busy_q;
  assign valid_o = busy_q;
  assign first_o = busy_q && (idx_q == '0);
  assign last_o  = busy_q && (idx_q == IDX_LAST);

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(first_o) && $stable(last_o));
  // R10
  end_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_o |=> !valid_o && !busy_o);
  // R2
  first_is_preamble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |-> valid_o && data_o == 8'h55 && !last_o);
  // R8
  busy_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !(ready_i && last_o) |=> busy_o);
  // R8
  start_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && first_o);
endmodule

// File: tb/pause_frame_gen_tb.sv
`timescale 1ns/1ps
module pause_frame_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] quanta_i = '0;
  logic [47:0] src_addr_i = '0;
  logic        ready_i = 1'b0;
  logic        busy_o, valid_o, first_o, last_o;
  logic [7:0]  data_o;

  always #2.5 clk_i = ~clk_i;

  pause_frame_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .quanta_i(quanta_i),
    .src_addr_i(src_addr_i), .busy_o(busy_o), .data_o(data_o), .valid_o(valid_o),
    .ready_i(ready_i), .first_o(first_o), .last_o(last_o)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  // {quanta, source address, ready mode, inject start mid-frame}
  localparam int NV = 5;
  localparam logic [15:0] V_Q  [NV] = '{16'h0000, 16'hFFFF, 16'h1234, 16'h00A5, 16'h8001};
  localparam logic [47:0] V_SA [NV] = '{48'h001122334455, 48'hFEDCBA987654,
                                        48'h0A0B0C0D0E0F, 48'h5A5A00FF0001, 48'h800000000001};
  localparam int          V_M  [NV] = '{0, 1, 2, 2, 0};
  localparam bit          V_INJ[NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int n);
    if (n < 8)  return "R2";
    if (n < 14) return "R3";
    if (n < 20) return "R4";
    if (n < 24) return "R5";
    if (n < 68) return "R6";
    return "R7";
  endfunction

  function automatic logic [31:0] crc_bits(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ b[k]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic run_frame(input logic [15:0] q, input logic [47:0] sa, input int mode, input bit inj);
    logic [7:0] exp [72];
    logic [7:0] rx [72];
    logic [7:0] da [6] = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01};
    logic [31:0] c;
    logic [7:0] held = '0;
    logic held_f = 0, held_l = 0;
    bit pend = 0;
    int n = 0, guard = 0;
    for (int k = 0; k < 7; k++) exp[k] = 8'h55;
    exp[7] = 8'hD5;
    for (int k = 0; k < 6; k++) exp[8+k] = da[k];
    for (int k = 0; k < 6; k++) exp[14+k] = sa[47-8*k -: 8];
    exp[20] = 8'h88; exp[21] = 8'h08; exp[22] = 8'h00; exp[23] = 8'h01;
    exp[24] = q[15:8]; exp[25] = q[7:0];
    for (int k = 26; k < 68; k++) exp[k] = 8'h00;
    c = 32'hFFFFFFFF;
    for (int k = 8; k < 68; k++) c = crc_bits(c, exp[k]);
    c = ~c;
    for (int k = 0; k < 4; k++) exp[68+k] = c[8*k +: 8];

    @(negedge clk_i);
    start_i = 1; quanta_i = q; src_addr_i = sa;
    @(negedge clk_i);
    start_i = 0; quanta_i = ~q; src_addr_i = ~sa;
    chk(busy_o && valid_o, "R8 busy after start", {30'h0, busy_o, valid_o}, 32'h3);
    while (n < 72 && guard < 5000) begin
      guard++;
      case (mode)
        0: ready_i = 1'b1;
        1: ready_i = guard[0];
        default: begin lfsr = {lfsr[14:0], lfsr[15]^lfsr[13]^lfsr[12]^lfsr[10]}; ready_i = lfsr[0]; end
      endcase
      start_i = inj && (n == 30 || n == 71);
      if (pend)
        chk(valid_o && data_o == held && first_o == held_f && last_o == held_l,
            "R9 hold", {23'h0, valid_o, data_o}, {23'h0, 1'b1, held});
      pend = 0;
      if (valid_o && ready_i) begin
        chk(data_o == exp[n], tag_of(n), {24'h0, data_o}, {24'h0, exp[n]});
        chk(first_o == (n == 0), "R2 first", {31'h0, first_o}, {31'h0, n == 0});
        chk(last_o == (n == 71), "R10 last", {31'h0, last_o}, {31'h0, n == 71});
        rx[n] = data_o;
        n++;
      end else if (valid_o) begin
        held = data_o; held_f = first_o; held_l = last_o; pend = 1;
      end
      @(negedge clk_i);
    end
    ready_i = 0;
    start_i = 0;
    chk(n == 72, "R2 length", n, 72);
    chk(!valid_o && !busy_o, "R10 idle after last", {30'h0, valid_o, busy_o}, 0);
    if (n == 72) begin
      c = 32'hFFFFFFFF;
      for (int k = 8; k < 72; k++) c = crc_bits(c, rx[k]);
      chk(c == 32'hDEBB20E3, "R7 residue", c, 32'hDEBB20E3);
      if (inj)
        chk({rx[14], rx[15], rx[16], rx[17], rx[18], rx[19], rx[24], rx[25]} == {sa, q},
            "R8 start during frame ignored", {rx[24], rx[25]}, q);
    end
    @(negedge clk_i);
    chk(!valid_o, "R8 late start ignored", {31'h0, valid_o}, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    chk(!valid_o && !busy_o && !first_o && !last_o, "R1 in reset",
        {28'h0, valid_o, busy_o, first_o, last_o}, 0);
    start_i = 1;
    @(negedge clk_i);
    chk(!valid_o && !busy_o, "R1 start held in reset", {30'h0, valid_o, busy_o}, 0);
    start_i = 0;
    rst_ni = 1;
    @(negedge clk_i);
    chk(!valid_o && !busy_o && !first_o && !last_o, "R1 after reset",
        {28'h0, valid_o, busy_o, first_o, last_o}, 0);

    for (int v = 0; v < NV; v++)
      run_frame(V_Q[v], V_SA[v], V_M[v], V_INJ[v]);

    // reset in mid-frame, then a clean frame
    @(negedge clk_i);
    start_i = 1; quanta_i = 16'h4242; src_addr_i = 48'h111111111111;
    @(negedge clk_i);
    start_i = 0; ready_i = 1;
    repeat (10) @(negedge clk_i);
    rst_ni = 0; ready_i = 0;
    @(negedge clk_i);
    chk(!valid_o && !busy_o, "R1 reset mid-frame", {30'h0, valid_o, busy_o}, 0);
    rst_ni = 1;
    run_frame(16'h7FFF, 48'h020000000002, 1, 1'b0);

    finish_run();
  end
endmodule